// File: doc/BRIEF.md
# Infrared Raw Symbol Capture

This block watches the demodulated output of an infrared receiver and turns the waveform into a list of timed symbols. An idle line sits high. A symbol starts when the line goes low and runs until the next falling edge. The block measures the low (pulse) phase and the high (space) phase that follows it. Each width is counted in units of ten base ticks, and one base tick is one microsecond once the prescaler matches the clock. Both widths of a symbol go into one FIFO word. A space that runs on until the whole symbol reaches a configured maximum width closes the stream. That symbol is stored as an end marker and flagged as a timeout.

Software sees a word-addressed register port. It enables the block and waits for the busy indication to drop, then writes the configuration and writes the start register to begin capture. While capture runs, software reads the entry count and pops entries one by one from the data register. Three sticky event flags (enough symbols received, timeout, overflow) feed one interrupt line through an active-low mask. When the FIFO overflows, its contents stay in place, so software drains them before clearing the flag.

Top module: `ir_symbol_capture`

## Requirements
- R1: After reset, enable, busy, count and status read 0, irq_o is low, the config register reads 0x3E80_0080 and the mask register reads 0x0000_0700. Byte offsets: enable 0x00, config 0x04, busy 0x08, count 0x0C, data 0x10, mask 0x14, status 0x18, clear 0x1C, start 0x20.
- R2: Writing 1 to enable bit 0 while disabled makes busy read 1 for INIT_CYCLES cycles and 0 after that. A start write while busy is ignored, and line activity then stores nothing.
- R3: With prescaler field P (config bits 6:0) the width unit is U = 10*(P+1) clocks. A phase lasting D clocks is stored as floor((D-1)/U) units. The low width goes in entry bits 15:0 and the high width in entry bits 31:16.
- R4: A falling edge that ends a space stores the entry of the symbol before it and starts timing a new symbol.
- R5: When low plus high width reaches the maximum width (config bits 31:16), the entry is stored as an end marker whose widths add up to that maximum, capture waits for a new falling edge, and status bit 9 sets.
- R6: The count register returns the number of stored entries. Each data read returns the oldest entry and removes it. A data read while empty returns 0 and changes nothing.
- R7: Status bit 8 sets once the count exceeds the level field (config bits 13:8), and not before.
- R8: The FIFO holds FIFO_DEPTH entries. A store while it is full drops the new entry, keeps the stored ones and sets status bit 10.
- R9: Writing 1 to clear-register bits 16, 17 and 18 clears status bits 8, 9 and 10 respectively, and leaves the other flags alone.
- R10: irq_o is high exactly when some status flag is set whose mask bit (mask bits 10:8 in the same order) is 0.
- R11: Line pulses shorter than FILT_LEN clocks are filtered out and do not split a symbol.
- R12: Capture runs only with config bit 7 (raw mode) set and format field bits 15:14 equal to 0. Otherwise line activity stores nothing.
- R13: Writing 0 to enable stops capture, and later line activity stores nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ir_line_i | input | 1 | Demodulated receiver line, idle high, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe; a data read pops one entry |
| reg_addr_i | input | 6 | Byte address of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, valid in the strobe cycle |
| irq_o | output | 1 | Interrupt request, level |

## Verification
A wrong phase state or an off-by-one in the unit timer shows in the popped entry of the affected symbol. The error appears as soon as the next falling edge or the timeout stores that symbol. A wrong FIFO pointer or count appears in the count register and in the entry order on the next pop. Overflow handling errors show either as a count above the depth or as lost older entries. A flag that is not sticky, or that is cleared by the wrong clear bit, shows in the status register and on irq_o in the cycle after the event or the clear write.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;

  // word index of each register (byte address bits 5:2)
  localparam logic [3:0] RI_ENABLE = 4'd0;
  localparam logic [3:0] RI_CONFIG = 4'd1;
  localparam logic [3:0] RI_BUSY   = 4'd2;
  localparam logic [3:0] RI_COUNT  = 4'd3;
  localparam logic [3:0] RI_DATA   = 4'd4;
  localparam logic [3:0] RI_MASK   = 4'd5;
  localparam logic [3:0] RI_STATUS = 4'd6;
  localparam logic [3:0] RI_CLEAR  = 4'd7;
  localparam logic [3:0] RI_START  = 4'd8;

  localparam logic [31:0] CFG_RESET  = 32'h3E80_0080;
  localparam logic [2:0]  MASK_RESET = 3'b111;

  typedef struct packed {
    logic [15:0] maxw;
    logic [1:0]  fmt;
    logic [5:0]  level;
    logic        raw;
    logic [6:0]  presc;
  } cfg_t;

  typedef enum logic [1:0] {M_IDLE, M_LOW, M_HIGH} mstate_e;

  function automatic logic [31:0] entry_pack(logic [15:0] lo, logic [15:0] hi);
    return {hi, lo};
  endfunction

  function automatic logic reached_limit(logic [15:0] lo, logic [15:0] hi,
                                         logic [15:0] mx);
    return ({1'b0, lo} + {1'b0, hi}) >= {1'b0, mx};
  endfunction

  function automatic logic level_met(int unsigned cnt, int unsigned lvl);
    return cnt > lvl;
  endfunction

endpackage

// File: rtl/ir_line_filter.sv
module ir_line_filter #(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic fall_o,
  output logic rise_o
);
  logic [1:0]          sync_q;
  logic [FILT_LEN-1:0] hist_q;
  logic                level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      hist_q  <= '1;
      level_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
      if (&hist_q)       level_q <= 1'b1;
      else if (~|hist_q) level_q <= 1'b0;
    end
  end

  assign fall_o = level_q && (~|hist_q);
  assign rise_o = !level_q && (&hist_q);

  a_r11_edge_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fall_o, rise_o}));
  a_r11_no_bounce: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !rise_o);
endmodule

// File: rtl/ir_width_meter.sv
module ir_width_meter
  import ir_cap_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run_i,
  input  logic [6:0]  presc_i,
  input  logic [15:0] maxw_i,
  input  logic        fall_i,
  input  logic        rise_i,
  output logic        push_o,
  output logic        end_o,
  output logic [31:0] entry_o
);
  mstate_e     st_q;
  logic [6:0]  pre_q;
  logic [3:0]  dec_q;
  logic [15:0] low_q, high_q;
  logic        unit_tick;
  logic [15:0] low_inc, high_inc;

  assign unit_tick = (pre_q == presc_i) && (dec_q == 4'd9);
  assign low_inc   = low_q + 16'd1;
  assign high_inc  = high_q + 16'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= M_IDLE;
      pre_q   <= '0;
      dec_q   <= '0;
      low_q   <= '0;
      high_q  <= '0;
      push_o  <= 1'b0;
      end_o   <= 1'b0;
      entry_o <= '0;
    end else begin
      push_o <= 1'b0;
      end_o  <= 1'b0;
      if (!run_i) begin
        st_q  <= M_IDLE;
        pre_q <= '0;
        dec_q <= '0;
      end else begin
        case (st_q)
          M_IDLE: begin
            if (fall_i) begin
              st_q   <= M_LOW;
              low_q  <= '0;
              high_q <= '0;
              pre_q  <= '0;
              dec_q  <= '0;
            end
          end
          M_LOW: begin
            if (rise_i) begin
              st_q  <= M_HIGH;
              pre_q <= '0;
              dec_q <= '0;
            end else if (unit_tick) begin
              pre_q <= '0;
              dec_q <= '0;
              low_q <= low_inc;
              if (reached_limit(low_inc, high_q, maxw_i)) begin
                push_o  <= 1'b1;
                end_o   <= 1'b1;
                entry_o <= entry_pack(low_inc, high_q);
                st_q    <= M_IDLE;
              end
            end else if (pre_q == presc_i) begin
              pre_q <= '0;
              dec_q <= dec_q + 4'd1;
            end else begin
              pre_q <= pre_q + 7'd1;
            end
          end
          M_HIGH: begin
            if (fall_i) begin
              push_o  <= 1'b1;
              entry_o <= entry_pack(low_q, high_q);
              st_q    <= M_LOW;
              low_q   <= '0;
              high_q  <= '0;
              pre_q   <= '0;
              dec_q   <= '0;
            end else if (unit_tick) begin
              pre_q  <= '0;
              dec_q  <= '0;
              high_q <= high_inc;
              if (reached_limit(low_q, high_inc, maxw_i)) begin
                push_o  <= 1'b1;
                end_o   <= 1'b1;
                entry_o <= entry_pack(low_q, high_inc);
                st_q    <= M_IDLE;
              end
            end else if (pre_q == presc_i) begin
              pre_q <= '0;
              dec_q <= dec_q + 4'd1;
            end else begin
              pre_q <= pre_q + 7'd1;
            end
          end
          default: st_q <= M_IDLE;
        endcase
      end
    end
  end

  a_r5_end_is_push: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |-> push_o);
  a_r5_end_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    end_o |-> (({1'b0, entry_o[15:0]} + {1'b0, entry_o[31:16]}) >= {1'b0, $past(maxw_i)}));
endmodule

// File: rtl/ir_symbol_fifo.sv
module ir_symbol_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned WIDTH = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_i,
  input  logic [WIDTH-1:0]             din_i,
  input  logic                         pop_i,
  output logic [WIDTH-1:0]             dout_o,
  output logic [$clog2(DEPTH+1)-1:0]   count_o,
  output logic                         empty_o,
  output logic                         drop_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full, pop_ok, push_ok;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign pop_ok  = pop_i && !empty_o;
  assign push_ok = push_i && (!full || pop_ok);
  assign drop_o  = push_i && !push_ok;
  assign dout_o  = mem_q[rd_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk) begin
    if (push_ok) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
      if (pop_ok)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  a_r8_drop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    drop_o |=> cnt_q == $past(cnt_q));
  a_r6_pop_dec: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !empty_o && !push_i) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/ir_symbol_capture.sv
module ir_symbol_capture
  import ir_cap_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH  = 16,
  parameter int unsigned INIT_CYCLES = 16,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ir_line_i,
  input  logic        reg_wr_i,
  input  logic        reg_rd_i,
  input  logic [5:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_o
);
  localparam int unsigned CNT_W  = $clog2(FIFO_DEPTH + 1);
  localparam int unsigned BUSY_W = $clog2(INIT_CYCLES + 1);

  logic              en_q, run_q;
  logic [BUSY_W-1:0] busy_q;
  logic [31:0]       cfg_q;
  cfg_t              cfg;
  logic [2:0]        mask_q, flags_q;
  logic [3:0]        idx;
  logic              acc_ok, wr_en, wr_cfg, wr_mask, wr_clr, wr_start, rd_pop;
  logic              line_fall, line_rise, cap_run;
  logic              sym_push, sym_end;
  logic [31:0]       sym_entry, fifo_dout;
  logic [CNT_W-1:0]  fifo_cnt;
  logic              fifo_empty, fifo_drop, lvl_hit, busy;

  assign cfg      = cfg_t'(cfg_q);
  assign idx      = reg_addr_i[5:2];
  assign acc_ok   = (reg_addr_i[1:0] == 2'b00);
  assign wr_en    = reg_wr_i && acc_ok && (idx == RI_ENABLE);
  assign wr_cfg   = reg_wr_i && acc_ok && (idx == RI_CONFIG);
  assign wr_mask  = reg_wr_i && acc_ok && (idx == RI_MASK);
  assign wr_clr   = reg_wr_i && acc_ok && (idx == RI_CLEAR);
  assign wr_start = reg_wr_i && acc_ok && (idx == RI_START);
  assign rd_pop   = reg_rd_i && acc_ok && (idx == RI_DATA);
  assign busy     = (busy_q != '0);
  assign cap_run  = run_q && cfg.raw && (cfg.fmt == 2'b00);
  assign lvl_hit  = level_met(int'(fifo_cnt), int'(cfg.level));

  ir_line_filter #(.FILT_LEN(FILT_LEN)) i_filter (
    .clk    (clk),
    .rst_n  (rst_n),
    .line_i (ir_line_i),
    .fall_o (line_fall),
    .rise_o (line_rise)
  );

  ir_width_meter i_meter (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (cap_run),
    .presc_i (cfg.presc),
    .maxw_i  (cfg.maxw),
    .fall_i  (line_fall),
    .rise_i  (line_rise),
    .push_o  (sym_push),
    .end_o   (sym_end),
    .entry_o (sym_entry)
  );

  ir_symbol_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(32)) i_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (sym_push),
    .din_i   (sym_entry),
    .pop_i   (rd_pop),
    .dout_o  (fifo_dout),
    .count_o (fifo_cnt),
    .empty_o (fifo_empty),
    .drop_o  (fifo_drop)
  );

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      run_q  <= 1'b0;
      busy_q <= '0;
      cfg_q  <= CFG_RESET;
      mask_q <= MASK_RESET;
    end else begin
      if (busy) busy_q <= busy_q - 1'b1;
      if (wr_en) begin
        if (!reg_wdata_i[0]) begin
          en_q   <= 1'b0;
          run_q  <= 1'b0;
          busy_q <= '0;
        end else if (!en_q) begin
          en_q   <= 1'b1;
          busy_q <= BUSY_W'(INIT_CYCLES);
        end
      end
      if (wr_start && en_q && !busy) run_q <= 1'b1;
      if (wr_cfg)  cfg_q  <= reg_wdata_i;
      if (wr_mask) mask_q <= reg_wdata_i[10:8];
    end
  end

  // sticky event flags: [0] symbols received, [1] timeout, [2] overflow
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      for (int i = 0; i < 3; i++) begin
        if (wr_clr && reg_wdata_i[16+i]) flags_q[i] <= 1'b0;
      end
      if (lvl_hit)   flags_q[0] <= 1'b1;
      if (sym_end)   flags_q[1] <= 1'b1;
      if (fifo_drop) flags_q[2] <= 1'b1;
    end
  end

  assign irq_o = |(flags_q & ~mask_q);

  always_comb begin
    reg_rdata_o = '0;
    if (acc_ok) begin
      case (idx)
        RI_ENABLE: reg_rdata_o = {31'd0, en_q};
        RI_CONFIG: reg_rdata_o = cfg_q;
        RI_BUSY:   reg_rdata_o = {31'd0, busy};
        RI_COUNT:  reg_rdata_o = 32'(fifo_cnt);
        RI_DATA:   reg_rdata_o = fifo_empty ? 32'd0 : fifo_dout;
        RI_MASK:   reg_rdata_o = {21'd0, mask_q, 8'd0};
        RI_STATUS: reg_rdata_o = {21'd0, flags_q, 8'd0};
        default:   reg_rdata_o = '0;
      endcase
    end
  end

  a_r2_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_start && busy && !run_q) |=> !run_q);
  a_r13_disable_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !reg_wdata_i[0]) |=> (!run_q && !en_q));
  a_r9_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && reg_wdata_i[18] && !fifo_drop) |=> !flags_q[2]);
  a_r8_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_drop |=> flags_q[2]);
  a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (flags_q != 3'b000));
endmodule

// File: tb/test_ir_symbol_capture.sv
module test_ir_symbol_capture;
  localparam int DEPTH = 16;
  localparam int INIT  = 16;
  localparam logic [5:0] A_EN = 6'h00, A_CFG = 6'h04, A_BUSY = 6'h08,
                         A_CNT = 6'h0C, A_DATA = 6'h10, A_MASK = 6'h14,
                         A_STAT = 6'h18, A_CLR = 6'h1C, A_START = 6'h20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ir_line = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ir_symbol_capture #(.FIFO_DEPTH(DEPTH), .INIT_CYCLES(INIT), .FILT_LEN(3)) i_ir_symbol_capture (
    .clk(clk), .rst_n(rst_n), .ir_line_i(ir_line),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .irq_o(irq)
  );

  function automatic logic [31:0] cfg_word(int mx, int fmt, int lvl, int raw, int p);
    return (32'(mx) << 16) | (32'(fmt) << 14) | (32'(lvl) << 8) | (32'(raw) << 7) | 32'(p);
  endfunction

  function automatic int units(int dur, int p);
    return (dur - 1) / (10 * (p + 1));
  endfunction

  function automatic logic [31:0] ent(int lo, int hi);
    return (32'(hi) << 16) | 32'(lo & 16'hFFFF);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic rd_chk(string req, logic [5:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    chk(req, d, exp);
  endtask

  task automatic irq_chk(string req, logic exp);
    @(negedge clk);
    #1 chk(req, {31'd0, irq}, {31'd0, exp});
  endtask

  task automatic phase(logic lvl, int n);
    @(negedge clk);
    ir_line = lvl;
    repeat (n - 1) @(negedge clk);
  endtask

  task automatic drain();
    logic [31:0] c, d;
    rd(A_CNT, c);
    for (int i = 0; i < int'(c); i++) rd(A_DATA, d);
  endtask

  task automatic scratch_stream();
    phase(0, 30); phase(1, 30); phase(0, 30); phase(1, 700);
  endtask

  task automatic random_stream();
    int p, u, lo[5], hi[5];
    logic [31:0] d;
    p = $urandom_range(0, 2);
    u = 10 * (p + 1);
    wr(A_CFG, cfg_word(60, 0, 3, 1, p));
    wr(A_MASK, 32'h0);
    for (int i = 0; i < 5; i++) begin
      lo[i] = $urandom_range(1, 20);
      hi[i] = $urandom_range(1, 20);
    end
    for (int i = 0; i < 5; i++) begin
      phase(0, lo[i] * u + 5);
      if (i < 4) phase(1, hi[i] * u + 5);
    end
    phase(1, (60 - lo[4]) * u + 40);
    rd_chk("R6 count after stream", A_CNT, 32'd5);
    rd_chk("R5 R7 status after stream", A_STAT, 32'h300);
    irq_chk("R10 irq unmasked", 1'b1);
    for (int i = 0; i < 4; i++) begin
      rd(A_DATA, d);
      chk("R3 R4 entry widths", d, ent(units(lo[i] * u + 5, p), units(hi[i] * u + 5, p)));
    end
    rd(A_DATA, d);
    chk("R5 end marker", d, ent(lo[4], 60 - lo[4]));
    rd_chk("R6 count drained", A_CNT, 32'd0);
    rd_chk("R6 empty pop", A_DATA, 32'd0);
    rd_chk("R6 count after empty pop", A_CNT, 32'd0);
    wr(A_CLR, 32'h0002_0000);
    rd_chk("R9 timeout clear only", A_STAT, 32'h100);
    wr(A_CLR, 32'h0001_0000);
    rd_chk("R9 rcv clear", A_STAT, 32'h0);
    irq_chk("R10 irq after clear", 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk("R1 enable", A_EN, 32'd0);
    rd_chk("R1 busy", A_BUSY, 32'd0);
    rd_chk("R1 count", A_CNT, 32'd0);
    rd_chk("R1 status", A_STAT, 32'd0);
    rd_chk("R1 config", A_CFG, 32'h3E80_0080);
    rd_chk("R1 mask", A_MASK, 32'h700);
    irq_chk("R1 irq", 1'b0);

    // R2 enable, busy window, start ignored while busy
    wr(A_EN, 32'd1);
    rd_chk("R2 busy after enable", A_BUSY, 32'd1);
    wr(A_START, 32'd1);
    repeat (INIT + 2) @(negedge clk);
    rd_chk("R2 busy finished", A_BUSY, 32'd0);
    wr(A_CFG, cfg_word(60, 0, 3, 1, 0));
    scratch_stream();
    rd_chk("R2 start while busy ignored", A_CNT, 32'd0);
    wr(A_START, 32'd1);

    // R7 threshold and R10 masking, level 1 -> flag at count 2
    wr(A_CFG, cfg_word(60, 0, 1, 1, 0));
    wr(A_MASK, 32'h700);
    phase(0, 20); phase(1, 20); phase(0, 20);
    rd_chk("R4 one entry after fall", A_CNT, 32'd1);
    rd_chk("R7 below level", A_STAT, 32'd0);
    phase(1, 20); phase(0, 20);
    rd_chk("R7 count two", A_CNT, 32'd2);
    rd_chk("R7 level reached", A_STAT, 32'h100);
    irq_chk("R10 masked", 1'b0);
    wr(A_MASK, 32'h600);
    irq_chk("R10 rcv unmasked", 1'b1);
    wr(A_MASK, 32'h500);
    irq_chk("R10 only timeout enabled", 1'b0);
    phase(1, 640);
    rd_chk("R5 timeout flag", A_STAT, 32'h300);
    irq_chk("R10 timeout unmasked", 1'b1);
    drain();
    wr(A_CLR, 32'h0007_0000);
    rd_chk("R9 clear all", A_STAT, 32'd0);

    // constrained random streams
    for (int k = 0; k < 3; k++) random_stream();

    // R11 glitch inside a space
    wr(A_CFG, cfg_word(60, 0, 3, 1, 0));
    phase(0, 30); phase(1, 20); phase(0, 2); phase(1, 20); phase(0, 30);
    phase(1, 640);
    rd_chk("R11 glitch not split", A_CNT, 32'd2);
    rd_chk("R11 space spans glitch", A_DATA, ent(2, 4));
    rd_chk("R5 end after glitch", A_DATA, ent(2, 58));
    wr(A_CLR, 32'h0007_0000);

    // R8 overflow: 18 stores into 16 entries
    for (int i = 0; i < 18; i++) begin
      phase(0, (1 + i % 5) * 10 + 5);
      phase(1, 25);
    end
    phase(1, 640);
    rd_chk("R8 count at depth", A_CNT, DEPTH);
    rd(A_STAT, d);
    chk("R8 overflow flag", d & 32'h400, 32'h400);
    for (int i = 0; i < DEPTH; i++) begin
      rd(A_DATA, d);
      chk("R8 kept entries", d, ent(1 + i % 5, 2));
    end
    rd_chk("R8 drained", A_CNT, 32'd0);
    wr(A_CLR, 32'h0004_0000);
    rd(A_STAT, d);
    chk("R9 overflow cleared", d & 32'h400, 32'h0);
    wr(A_CLR, 32'h0007_0000);

    // R12 raw mode off, then non-zero format
    wr(A_CFG, cfg_word(60, 0, 3, 0, 0));
    scratch_stream();
    rd_chk("R12 raw off", A_CNT, 32'd0);
    wr(A_CFG, cfg_word(60, 1, 3, 1, 0));
    scratch_stream();
    rd_chk("R12 format one", A_CNT, 32'd0);

    // R13 disable
    wr(A_CFG, cfg_word(60, 0, 3, 1, 0));
    wr(A_EN, 32'd0);
    scratch_stream();
    rd_chk("R13 disabled count", A_CNT, 32'd0);
    rd_chk("R13 enable reads 0", A_EN, 32'd0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule